// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block watches sixteen input pins of a small microcontroller and turns their activity into interrupt requests for the CPU-side interrupt controller. Four dedicated lines each have their own sense setting. A line can request on a falling edge, on a rising edge, on any edge, or for as long as it is held low. Twelve further pins are pin-change sources. They are split into a low group of four pins and a high group of eight. Each group has its own pin mask, and a toggle on any selected pin of a group sets that group's flag.

All pins are sampled through two-flop synchronizers in the block's single clock domain. Detection uses only the pin value. A pin that the chip itself drives as an output therefore still triggers, and software can use this to raise interrupts. Edge and toggle events latch into flags, and software clears a flag by writing a one to it. A level-mode line latches nothing: its request follows the synchronized pin directly. Every request is gated by a per-source enable bit and by a single global-enable input.

A small register bus gives access to the sense, enable, mask and flag registers. Writes take effect on the clock edge, and reads are combinational.

Top module: `xint_ctrl`

## Requirements
- R1: After reset every register reads 0 and both request outputs are 0. The synchronizer stages reset to 1, so pins that are held high through reset cause no event.
- R2: The register map is as follows, with unused bits and address 7 reading 0. Address 0 is sense control, with two bits per line and line n at bits 2n+1:2n. Address 1 holds the line enables in bits 3:0. Address 2 holds the line flags in bits 3:0. Address 3 holds the group enables, group 0 at bit 0 and group 1 at bit 1. Address 4 holds the group flags in the same bit order. Address 5 is the group 0 mask, where bit j selects pin-change input j. Address 6 is the group 1 mask, where bit j selects pin-change input j+4.
- R3: When the global enable input is 0, all request outputs are 0, whatever the flags and levels are.
- R4: Sense code 00 selects low level. The line requests while its synchronized pin is 0, which is two clock edges after the pin changes. Its flag is never set in this mode.
- R5: Sense code 01 selects any edge, 10 selects falling edge and 11 selects rising edge. A qualifying edge sets the line flag on the third clock edge after the pin changes, whether or not the line is enabled.
- R6: Writing 1 to a bit at address 2 or address 4 clears that flag. Writing 0 leaves the flag unchanged.
- R7: A toggle in either direction on a masked pin of a group sets that group's flag on the third clock edge after the toggle. A toggle on an unmasked pin has no effect.
- R8: An edge-mode line request equals its flag AND its enable AND the global enable. A group request equals the group flag AND the group enable AND the global enable.
- R9: If a flag is set and cleared by a write in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gie | input | 1 | Global interrupt enable |
| ext_pin | input | 4 | Dedicated interrupt line pins |
| pc_pin | input | 12 | Pin-change inputs (group 0: 3:0, group 1: 11:4) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| ext_req | output | 4 | Dedicated line interrupt requests |
| pc_req | output | 2 | Pin-change group requests |

## Verification
Two functions can fall in the same cycle: a flag being set by a synchronized edge, and a write-one clear of that same flag. The bench provokes the clash by timing the clear write to the third edge after the pin moves, which is exactly the edge where the set lands. It then reads the flag back and expects it to be 1. A long random phase mixes pin toggles, writes and global-enable changes, so the clash also occurs by chance. A queue-based reference model compares the read data and both request outputs on every cycle.

// File: rtl/xint_ctrl.sv
module xint_ctrl #(
  parameter int EXT_N = 4,
  parameter int PC_LO = 4,
  parameter int PC_HI = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gie,
  input  logic [3:0]       ext_pin,
  input  logic [11:0]      pc_pin,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [3:0]       ext_req,
  output logic [1:0]       pc_req
);
  localparam int PC_N = PC_LO + PC_HI;
  localparam int IN_W = EXT_N + PC_N;
  localparam int SENSE_W = 2 * EXT_N;
  localparam logic [2:0] A_SENSE = 3'd0, A_EEN = 3'd1, A_EFLAG = 3'd2,
                         A_PEN = 3'd3, A_PFLAG = 3'd4, A_MASK0 = 3'd5, A_MASK1 = 3'd6;

  logic [IN_W-1:0] sy1, sy2, sy3;
  logic [SENSE_W-1:0] sense_r;
  logic [EXT_N-1:0] ext_en_r, ext_flag_r, ext_set, ext_clr, ext_lvl;
  logic [1:0] pc_en_r, pc_flag_r, pc_set, pc_clr;
  logic [PC_LO-1:0] mask0_r;
  logic [PC_HI-1:0] mask1_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
      sy3 <= '1;
    end else begin
      sy1 <= {pc_pin, ext_pin};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  wire [EXT_N-1:0] e_now = sy2[EXT_N-1:0];
  wire [EXT_N-1:0] e_old = sy3[EXT_N-1:0];
  wire [PC_N-1:0]  p_tgl = sy2[IN_W-1:EXT_N] ^ sy3[IN_W-1:EXT_N];

  always_comb
    for (int i = 0; i < EXT_N; i++) begin
      ext_lvl[i] = 1'b0;
      case (sense_r[2*i +: 2])
        2'b00:   begin ext_set[i] = 1'b0; ext_lvl[i] = 1'b1; end
        2'b01:   ext_set[i] = e_now[i] ^ e_old[i];
        2'b10:   ext_set[i] = e_old[i] & ~e_now[i];
        default: ext_set[i] = ~e_old[i] & e_now[i];
      endcase
    end

  assign pc_set  = {|(p_tgl[PC_N-1:PC_LO] & mask1_r), |(p_tgl[PC_LO-1:0] & mask0_r)};
  assign ext_clr = (bus_we && bus_addr == A_EFLAG) ? bus_wdata[EXT_N-1:0] : '0;
  assign pc_clr  = (bus_we && bus_addr == A_PFLAG) ? bus_wdata[1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sense_r    <= '0;
      ext_en_r   <= '0;
      ext_flag_r <= '0;
      pc_en_r    <= '0;
      pc_flag_r  <= '0;
      mask0_r    <= '0;
      mask1_r    <= '0;
    end else begin
      ext_flag_r <= (ext_flag_r & ~ext_clr) | ext_set;
      pc_flag_r  <= (pc_flag_r & ~pc_clr) | pc_set;
      if (bus_we)
        case (bus_addr)
          A_SENSE: sense_r  <= bus_wdata[SENSE_W-1:0];
          A_EEN:   ext_en_r <= bus_wdata[EXT_N-1:0];
          A_PEN:   pc_en_r  <= bus_wdata[1:0];
          A_MASK0: mask0_r  <= bus_wdata[PC_LO-1:0];
          A_MASK1: mask1_r  <= bus_wdata[PC_HI-1:0];
          default: ;
        endcase
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SENSE: bus_rdata[SENSE_W-1:0] = sense_r;
      A_EEN:   bus_rdata[EXT_N-1:0]   = ext_en_r;
      A_EFLAG: bus_rdata[EXT_N-1:0]   = ext_flag_r;
      A_PEN:   bus_rdata[1:0]         = pc_en_r;
      A_PFLAG: bus_rdata[1:0]         = pc_flag_r;
      A_MASK0: bus_rdata[PC_LO-1:0]   = mask0_r;
      A_MASK1: bus_rdata[PC_HI-1:0]   = mask1_r;
      default: ;
    endcase
  end

  assign ext_req = {EXT_N{gie}} & ext_en_r & ((ext_lvl & ~e_now) | (~ext_lvl & ext_flag_r));
  assign pc_req  = {2{gie}} & pc_en_r & pc_flag_r;
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk #(
  parameter int EXT_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [2*EXT_N-1:0] sense_r,
  input logic [EXT_N-1:0] ext_flag_r,
  input logic [EXT_N-1:0] ext_set,
  input logic [1:0]       pc_flag_r,
  input logic [1:0]       pc_en_r,
  input logic [3:0]       ext_req,
  input logic [1:0]       pc_req
);
  p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (ext_req == 4'd0 && pc_req == 2'd0));

  for (genvar i = 0; i < EXT_N; i++) begin : g_line
    p_level_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sense_r[2*i +: 2]) == 2'b00) |-> !$rose(ext_flag_r[i]));
    p_zero_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == 3'd2 && !bus_wdata[i] && ext_flag_r[i]) |-> ext_flag_r[i]);
    p_one_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == 3'd2 && bus_wdata[i] && !ext_set[i]) |-> !ext_flag_r[i]);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ext_set[i]) |-> ext_flag_r[i]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    p_group_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pc_req[g] |-> (pc_flag_r[g] && pc_en_r[g]));
  end
endmodule

bind xint_ctrl xint_ctrl_chk #(.EXT_N(EXT_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sense_r(sense_r), .ext_flag_r(ext_flag_r),
  .ext_set(ext_set), .pc_flag_r(pc_flag_r), .pc_en_r(pc_en_r),
  .ext_req(ext_req), .pc_req(pc_req)
);

// File: tb/xint_ctrl_test.sv
`timescale 1ns/1ps
module xint_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, gie, bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] ext_pin, ext_req;
  logic [11:0] pc_pin;
  logic [1:0] pc_req;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  xint_ctrl uut (
    .clk(clk), .rst_n(rst_n), .gie(gie), .ext_pin(ext_pin), .pc_pin(pc_pin),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_req(ext_req), .pc_req(pc_req)
  );

  logic [7:0] m_sense;
  logic [3:0] m_een, m_eflag, m_mask0;
  logic [1:0] m_pen, m_pflag;
  logic [7:0] m_mask1;
  logic [15:0] hist[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sense = 0; m_een = 0; m_eflag = 0; m_mask0 = 0;
    m_pen = 0; m_pflag = 0; m_mask1 = 0;
    hist.delete();
    repeat (4) hist.push_back(16'hFFFF);
  endtask

  function automatic logic [7:0] mread(logic [2:0] a);
    case (a)
      3'd0: return m_sense;
      3'd1: return {4'd0, m_een};
      3'd2: return {4'd0, m_eflag};
      3'd3: return {6'd0, m_pen};
      3'd4: return {6'd0, m_pflag};
      3'd5: return {4'd0, m_mask0};
      3'd6: return m_mask1;
      default: return 8'd0;
    endcase
  endfunction

  task automatic model_edge();
    logic [15:0] cur, old, tg;
    logic [3:0] eset, eclr;
    logic [1:0] pset, pclr;
    hist.push_back({pc_pin, ext_pin});
    if (hist.size() > 4) void'(hist.pop_front());
    cur = hist[1];
    old = hist[0];
    for (int i = 0; i < 4; i++) begin
      int mode = int'(m_sense[2*i +: 2]);
      if (mode == 1)      eset[i] = cur[i] != old[i];
      else if (mode == 2) eset[i] = old[i] && !cur[i];
      else if (mode == 3) eset[i] = !old[i] && cur[i];
      else                eset[i] = 1'b0;
    end
    tg = cur ^ old;
    pset[0] = (tg[7:4] & m_mask0) != 0;
    pset[1] = (tg[15:8] & m_mask1) != 0;
    eclr = (bus_we && bus_addr == 3'd2) ? bus_wdata[3:0] : 4'd0;
    pclr = (bus_we && bus_addr == 3'd4) ? bus_wdata[1:0] : 2'd0;
    m_eflag = (m_eflag & ~eclr) | eset;
    m_pflag = (m_pflag & ~pclr) | pset;
    if (bus_we)
      case (bus_addr)
        3'd0: m_sense = bus_wdata;
        3'd1: m_een   = bus_wdata[3:0];
        3'd3: m_pen   = bus_wdata[1:0];
        3'd5: m_mask0 = bus_wdata[3:0];
        3'd6: m_mask1 = bus_wdata;
        default: ;
      endcase
  endtask

  function automatic logic [3:0] exp_ext();
    logic [3:0] r;
    logic [15:0] s = hist[2];
    for (int i = 0; i < 4; i++)
      r[i] = gie && m_een[i] && ((m_sense[2*i +: 2] == 2'b00) ? !s[i] : m_eflag[i]);
    return r;
  endfunction

  task automatic compare_all();
    check("R2 R5 R6 rdata", {24'd0, bus_rdata}, {24'd0, mread(bus_addr)});
    check("R3 R4 R8 ext_req", {28'd0, ext_req}, {28'd0, exp_ext()});
    check("R3 R7 R8 pc_req", {30'd0, pc_req}, {30'd0, {2{gie}} & m_pen & m_pflag});
  endtask

  task automatic step(logic we, logic [2:0] a, logic [7:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    bus_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 3'd2, 8'd0);
  endtask

  task automatic peek(logic [2:0] a, string tag, logic [7:0] exp);
    bus_addr = a;
    #1;
    check(tag, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gie = 1'b0; bus_we = 1'b0; bus_addr = 0; bus_wdata = 0;
    ext_pin = 4'hF; pc_pin = 12'hFFF;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) peek(3'(a), "R1 reset register", 8'd0);
    check("R1 reset ext_req", {28'd0, ext_req}, 0);
    check("R1 reset pc_req", {30'd0, pc_req}, 0);
    gie = 1'b1;
    idle(3);
    check("R1 no event from high pins", {28'd0, bus_rdata[3:0]}, 0);

    // R4 low-level mode on line 0
    step(1'b1, 3'd1, 8'h01);
    ext_pin[0] = 1'b0;
    step(1'b0, 3'd2, 8'd0);
    check("R4 level latency edge1", {31'd0, ext_req[0]}, 0);
    step(1'b0, 3'd2, 8'd0);
    check("R4 level request", {31'd0, ext_req[0]}, 1);
    idle(3);
    check("R4 level sets no flag", {24'd0, bus_rdata}, 0);
    ext_pin[0] = 1'b1;
    idle(2);
    check("R4 level request drops", {31'd0, ext_req[0]}, 0);

    // R5 rising edge mode on line 1
    step(1'b1, 3'd0, 8'b0000_1100);
    step(1'b1, 3'd1, 8'h03);
    ext_pin[1] = 1'b0;
    idle(4);
    check("R5 rise mode ignores fall", {24'd0, bus_rdata}, 0);
    ext_pin[1] = 1'b1;
    idle(2);
    check("R5 flag not before edge3", {24'd0, bus_rdata}, 0);
    idle(1);
    check("R5 flag on edge3", {24'd0, bus_rdata}, 8'h02);
    check("R8 edge request", {28'd0, ext_req}, 4'h2);

    // R6 write-one-to-clear
    step(1'b1, 3'd2, 8'h00);
    check("R6 zero write keeps flag", {24'd0, bus_rdata}, 8'h02);
    step(1'b1, 3'd2, 8'h02);
    check("R6 one write clears flag", {24'd0, bus_rdata}, 8'h00);

    // R9 set and clear in the same cycle
    ext_pin[1] = 1'b0;
    idle(4);
    ext_pin[1] = 1'b1;
    idle(2);
    step(1'b1, 3'd2, 8'h02);
    check("R9 set wins over clear", {24'd0, bus_rdata}, 8'h02);

    // R3 global enable gating
    gie = 1'b0;
    #1;
    check("R3 gie low masks request", {28'd0, ext_req}, 0);
    gie = 1'b1;
    #1;
    check("R3 gie high restores", {28'd0, ext_req}, 4'h2);
    step(1'b1, 3'd2, 8'h0F);

    // R5 any-edge mode on line 2, request disabled yet flag still set
    step(1'b1, 3'd0, 8'b0001_1100);
    ext_pin[2] = 1'b0;
    idle(3);
    check("R5 any edge flags when disabled", {24'd0, bus_rdata}, 8'h04);
    check("R8 disabled line no request", {31'd0, ext_req[2]}, 0);
    step(1'b1, 3'd2, 8'h04);
    ext_pin[2] = 1'b1;
    idle(3);
    step(1'b1, 3'd2, 8'h04);

    // R7 pin-change groups
    step(1'b1, 3'd6, 8'h04);
    step(1'b1, 3'd5, 8'h02);
    step(1'b1, 3'd3, 8'h03);
    pc_pin[5] = 1'b0;
    idle(4);
    step(1'b0, 3'd4, 8'd0);
    check("R7 unmasked toggle ignored", {24'd0, bus_rdata}, 0);
    pc_pin[6] = 1'b0;
    step(1'b0, 3'd4, 8'd0);
    step(1'b0, 3'd4, 8'd0);
    step(1'b0, 3'd4, 8'd0);
    check("R7 group1 flag", {24'd0, bus_rdata}, 8'h02);
    check("R8 group1 request", {30'd0, pc_req}, 2'b10);
    pc_pin[1] = 1'b0;
    step(1'b0, 3'd4, 8'd0);
    step(1'b0, 3'd4, 8'd0);
    step(1'b0, 3'd4, 8'd0);
    check("R7 group0 flag", {24'd0, bus_rdata}, 8'h03);
    step(1'b1, 3'd4, 8'h03);
    check("R6 group flags clear", {24'd0, bus_rdata}, 8'h00);
    peek(3'd7, "R2 address 7 reads zero", 8'd0);

    // Random phase against the model
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(15) == 0) ext_pin[$urandom_range(3)] ^= 1'b1;
      if ($urandom_range(7) == 0) pc_pin[$urandom_range(11)] ^= 1'b1;
      if ($urandom_range(63) == 0) gie = ~gie;
      if ($urandom_range(7) == 0)
        step(1'b1, 3'($urandom_range(7)), 8'($urandom));
      else
        step(1'b0, 3'($urandom_range(7)), 8'd0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule